// File: doc/BRIEF.md
# Iterative DES Block Cipher Round Engine

This block encrypts or decrypts one 64-bit block with the Data Encryption Standard. It has a single Feistel round circuit and reuses it once per clock cycle for sixteen cycles. A start pulse loads the input block through the initial permutation. Each following cycle runs one round with a 48-bit subkey. After the last round the halves go, without a swap, through the inverse initial permutation. The result is then placed on the output and a one-cycle done pulse is raised.

The key schedule sits outside this block. The engine publishes the subkey index it needs in every busy cycle. The neighbouring key-schedule logic must return that subkey combinationally in the same cycle. Encryption and decryption share the whole datapath and differ only in the order in which subkey indices are requested. The mode is captured at start, so the key schedule never needs to know the mode.

Top module: `des_iter_core`

## Requirements
- R1: While rst_n is low and after it is released, busy_o, done_o, round_idx_o and block_o are all zero.
- R2: A start_i high at a rising edge while busy_o is low is accepted, and busy_o is high from the next cycle.
- R3: With mode_i = 0 the output equals standard DES encryption of block_i under the key whose subkeys are supplied. Bit 63 of every 64-bit port is DES bit 1 (most significant first), and bit 47 of round_key_i is subkey bit 1.
- R4: With mode_i = 1 the same datapath performs DES decryption, so decrypting a ciphertext under the same subkeys returns the plaintext.
- R5: During the 16 busy cycles round_idx_o steps by one per cycle, 0 up to 15 for encryption and 15 down to 0 for decryption. round_key_i is used in the cycle that shows the matching index.
- R6: done_o is high for exactly one cycle, 16 clock edges after the accepting edge. busy_o is low in that cycle.
- R7: A start_i pulse while busy_o is high is ignored: the running operation's result, latency and index sequence are unchanged.
- R8: block_o changes only at the edge that raises done_o and holds its value until the next completion.
- R9: mode_i and block_i are sampled only at the accepting edge; changing them during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mode_i | input | 1 | 0 encrypt, 1 decrypt; sampled with start |
| block_i | input | 64 | Input block; sampled with start |
| round_key_i | input | 48 | Subkey for the index on round_idx_o, same cycle |
| busy_o | output | 1 | High during the 16 round cycles |
| done_o | output | 1 | One-cycle pulse when block_o is updated |
| round_idx_o | output | 4 | Subkey index requested from the key schedule |
| block_o | output | 64 | Result block, held until next completion |

## Verification
The bench builds the block with NUM_ROUNDS at its default of 16, which is the only value that gives a standard cipher. That setting lets three published encryption vectors and their decryptions be compared bit-exactly. Those vectors include an all-zero ciphertext, which exposes any permutation or S-box ordering slip. The 16-cycle window is short enough for the bench to trace every subkey index request and to inject start, mode and data changes mid-run, testing that they are ignored.

// File: rtl/des_iter_pkg.sv
// des_iter_pkg: widths, fixed permutations and S-box contents for the
// iterative DES engine. Bit 63 of a 64-bit vector is cipher bit 1.
// Assumes tables indexed from 1 as in the cipher standard.
package des_iter_pkg;

    localparam int BLOCK_W    = 64;
    localparam int HALF_W     = BLOCK_W / 2;
    localparam int SUBKEY_W   = 48;
    localparam int NUM_SBOX   = 8;
    localparam int SBOX_IN_W  = SUBKEY_W / NUM_SBOX;
    localparam int SBOX_OUT_W = HALF_W / NUM_SBOX;

    // Straight permutation applied after the S-boxes (1-based source bits).
    localparam int P_SRC [HALF_W] = '{
        16, 7, 20, 21, 29, 12, 28, 17,
         1, 15, 23, 26, 5, 18, 31, 10,
         2, 8, 24, 14, 32, 27, 3, 9,
        19, 13, 30, 6, 22, 11, 4, 25
    };

    // Source bit (1-based) feeding output position pos of the initial permutation.
    function automatic int ip_src(input int pos);
        int row;
        int col;
        row = pos / 8;
        col = pos % 8;
        if (row < 4)
            return 58 + 2 * row - 8 * col;
        else
            return 57 + 2 * (row - 4) - 8 * col;
    endfunction

    // Initial permutation.
    function automatic logic [BLOCK_W-1:0] init_perm(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        y = '0;
        for (int pos = 0; pos < BLOCK_W; pos++)
            y[BLOCK_W-1-pos] = x[BLOCK_W-ip_src(pos)];
        return y;
    endfunction

    // Inverse of the initial permutation.
    function automatic logic [BLOCK_W-1:0] final_perm(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        y = '0;
        for (int pos = 0; pos < BLOCK_W; pos++)
            y[BLOCK_W-ip_src(pos)] = x[BLOCK_W-1-pos];
        return y;
    endfunction

    // Expansion of a half block to subkey width, wrapping at the ends.
    function automatic logic [SUBKEY_W-1:0] expand_half(input logic [HALF_W-1:0] x);
        logic [SUBKEY_W-1:0] y;
        int src;
        y = '0;
        for (int pos = 0; pos < SUBKEY_W; pos++) begin
            src = ((4 * (pos / SBOX_IN_W) + (pos % SBOX_IN_W) + HALF_W - 1) % HALF_W) + 1;
            y[SUBKEY_W-1-pos] = x[HALF_W-src];
        end
        return y;
    endfunction

    // Straight permutation of the S-box output.
    function automatic logic [HALF_W-1:0] straight_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int pos = 0; pos < HALF_W; pos++)
            y[HALF_W-1-pos] = x[HALF_W-P_SRC[pos]];
        return y;
    endfunction

    // Contents of S-box id, entry 0 in the top nibble, entry = row*16 + col.
    function automatic logic [255:0] sbox_lut(input int id);
        case (id)
            0: return 256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D;
            1: return 256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9;
            2: return 256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C;
            3: return 256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E;
            4: return 256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453;
            5: return 256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D;
            6: return 256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C;
            default: return 256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B;
        endcase
    endfunction

endpackage

// File: rtl/des_sbox.sv
// des_sbox: one 6-to-4 substitution box of the cipher.
// Row comes from the outer input bits, column from the inner four bits.
// Assumes BOX_ID in 0..7.
module des_sbox
    import des_iter_pkg::*;
#(
    parameter int BOX_ID = 0
) (
    input  logic [SBOX_IN_W-1:0]  sel_i,
    output logic [SBOX_OUT_W-1:0] val_o
);

    localparam logic [255:0] LUT = sbox_lut(BOX_ID);

    logic [SBOX_IN_W-1:0] entry;
    logic [7:0]           bit_base;

    // Map input to table entry and to its bit offset from the LSB.
    always_comb begin
        entry    = {sel_i[SBOX_IN_W-1], sel_i[0], sel_i[SBOX_IN_W-2:1]};
        bit_base = {~entry, 2'b00};
        val_o    = LUT[bit_base +: SBOX_OUT_W];
    end

endmodule

// File: rtl/des_round_fn.sv
// des_round_fn: combinational cipher function f(R, K): expansion,
// subkey mixing, eight S-boxes and the straight permutation.
// Assumes subkey_i is already the correct one for this round.
module des_round_fn
    import des_iter_pkg::*;
(
    input  logic [HALF_W-1:0]   right_i,
    input  logic [SUBKEY_W-1:0] subkey_i,
    output logic [HALF_W-1:0]   f_o
);

    logic [SUBKEY_W-1:0] mixed;
    logic [HALF_W-1:0]   subst;

    // Expand the half block and mix in the subkey.
    always_comb mixed = expand_half(right_i) ^ subkey_i;

    for (genvar g = 0; g < NUM_SBOX; g++) begin : g_sbox
        des_sbox #(
            .BOX_ID(g)
        ) u_sbox (
            .sel_i(mixed[SUBKEY_W-1-g*SBOX_IN_W -: SBOX_IN_W]),
            .val_o(subst[HALF_W-1-g*SBOX_OUT_W -: SBOX_OUT_W])
        );
    end

    // Scatter the substituted bits.
    always_comb f_o = straight_perm(subst);

endmodule

// File: rtl/des_round_ctrl.sv
// des_round_ctrl: sequences one operation of NUM_ROUNDS round cycles.
// Accepts a start only when idle, latches the mode and produces the
// subkey index (ascending to encrypt, descending to decrypt).
module des_round_ctrl #(
    parameter int NUM_ROUNDS = 16,
    localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] round_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

    logic             busy_q;
    logic             done_q;
    logic             mode_q;
    logic [IDX_W-1:0] cnt_q;

    // Handshake decode.
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
        last_o = busy_q && (cnt_q == LAST_IDX);
    end

    // Round counter, busy flag, mode latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mode_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_o;
            if (load_o) begin
                busy_q <= 1'b1;
                mode_q <= mode_i;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_o) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end
            end
        end
    end

    // Subkey index request, reversed for decryption.
    always_comb begin
        busy_o      = busy_q;
        done_o      = done_q;
        round_idx_o = (busy_q && mode_q) ? (LAST_IDX - cnt_q) : cnt_q;
    end

endmodule

// File: rtl/des_iter_core.sv
// des_iter_core: DES encrypt/decrypt engine with one time-shared round.
// Assumes an external key schedule returns round_key_i combinationally
// for round_idx_o in every busy cycle.
module des_iter_core
    import des_iter_pkg::*;
#(
    parameter int NUM_ROUNDS = 16,
    localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [BLOCK_W-1:0]  block_i,
    input  logic [SUBKEY_W-1:0] round_key_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [IDX_W-1:0]    round_idx_o,
    output logic [BLOCK_W-1:0]  block_o
);

    logic               load;
    logic               step;
    logic               last;
    logic [HALF_W-1:0]  left_q;
    logic [HALF_W-1:0]  right_q;
    logic [HALF_W-1:0]  f_val;
    logic [HALF_W-1:0]  right_next;
    logic [BLOCK_W-1:0] permuted_in;
    logic [BLOCK_W-1:0] result_q;

    des_round_ctrl #(
        .NUM_ROUNDS(NUM_ROUNDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .load_o     (load),
        .step_o     (step),
        .last_o     (last),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .round_idx_o(round_idx_o)
    );

    des_round_fn u_fn (
        .right_i (right_q),
        .subkey_i(round_key_i),
        .f_o     (f_val)
    );

    // Initial permutation of the incoming block and the new right half.
    always_comb begin
        permuted_in = init_perm(block_i);
        right_next  = left_q ^ f_val;
    end

    // Half-block registers: load, then one Feistel round per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load) begin
            left_q  <= permuted_in[BLOCK_W-1:HALF_W];
            right_q <= permuted_in[HALF_W-1:0];
        end else if (step) begin
            left_q  <= right_q;
            right_q <= right_next;
        end
    end

    // Result register: unswapped halves through the final permutation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (last)
            result_q <= final_perm({right_next, right_q});
    end

    always_comb block_o = result_q;

endmodule

// File: rtl/des_iter_core_chk.sv
// des_iter_core_chk: protocol checks on the engine's ports, with its own
// cycle counter per operation. Attached to every des_iter_core by bind.
module des_iter_core_chk #(
    parameter int NUM_ROUNDS = 16,
    localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mode_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [IDX_W-1:0] round_idx_o,
    input logic [63:0]      block_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

    logic [IDX_W:0] run_cnt;
    logic           mode_seen;
    logic [IDX_W-1:0] exp_idx;

    // Count busy cycles since the last accepted start; remember its mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            mode_seen <= 1'b0;
        end else if (start_i && !busy_o) begin
            run_cnt   <= '0;
            mode_seen <= mode_i;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Expected subkey index for the current busy cycle.
    always_comb exp_idx = mode_seen ? (LAST_IDX - run_cnt[IDX_W-1:0]) : run_cnt[IDX_W-1:0];

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r5_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (round_idx_o == exp_idx));

    a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == (IDX_W+1)'(NUM_ROUNDS)) && !busy_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && run_cnt != (IDX_W+1)'(NUM_ROUNDS - 1)) |=> busy_o && !done_o);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(block_o));

endmodule

bind des_iter_core des_iter_core_chk #(
    .NUM_ROUNDS(NUM_ROUNDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .round_idx_o(round_idx_o),
    .block_o    (block_o)
);

// File: tb/des_iter_core_tb.sv
// des_iter_core_tb: acts as the key schedule, walks a vector table of
// known DES results in both modes, then runs directed corner tests.
module des_iter_core_tb;

    localparam int PC1_T [56] = '{
        57, 49, 41, 33, 25, 17, 9,  1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
    };
    localparam int PC2_T [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };
    // {key, plaintext, ciphertext}
    localparam logic [191:0] VEC [3] = '{
        {64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
        {64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000},
        {64'h0123456789ABCDEF, 64'h4E6F772069732074, 64'h3FA40E8A984D4815}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [63:0] block_i = '0;
    logic [47:0] round_key_i;
    logic        busy_o;
    logic        done_o;
    logic [3:0]  round_idx_o;
    logic [63:0] block_o;

    logic [47:0] subkeys [16];
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    des_iter_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .block_i    (block_i),
        .round_key_i(round_key_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .round_idx_o(round_idx_o),
        .block_o    (block_o)
    );

    // Bench key schedule: subkey for the requested index, same cycle.
    always_comb round_key_i = subkeys[round_idx_o];

    task automatic make_subkeys(input logic [63:0] key);
        logic [55:0] cd;
        logic [27:0] c;
        logic [27:0] d;
        logic [47:0] sk;
        for (int i = 0; i < 56; i++) cd[55-i] = key[64-PC1_T[i]];
        c = cd[55:28];
        d = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            int sh;
            sh = (r == 0 || r == 1 || r == 8 || r == 15) ? 1 : 2;
            for (int s = 0; s < sh; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int j = 0; j < 48; j++) sk[47-j] = cd[56-PC2_T[j]];
            subkeys[r] = sk;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One operation; optionally disturbs start/mode/block mid-run.
    task automatic run_op(input logic m, input logic [63:0] din, input bit disturb,
                          output logic [63:0] dout, output int lat,
                          output bit idx_ok, output bit pulse_ok);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; block_i = din;
        @(negedge clk);
        start_i = 1'b0;
        idx_ok = 1'b1;
        lat = -1;
        for (int i = 1; i <= 40; i++) begin
            if (i > 1) @(negedge clk);
            if (done_o) begin
                lat = i - 1;
                break;
            end
            if (!busy_o || round_idx_o !== (m ? 4'(15 - (i - 1)) : 4'(i - 1))) idx_ok = 1'b0;
            if (disturb && i == 5) begin
                start_i = 1'b1; mode_i = ~m; block_i = ~din;
            end else begin
                start_i = 1'b0; mode_i = m; block_i = din;
            end
        end
        dout = block_o;
        @(negedge clk);
        pulse_ok = !done_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] res;
        logic [63:0] held;
        int lat;
        bit idx_ok;
        bit pulse_ok;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", 64'(busy_o), 64'd0);
        check("R1", "done in reset", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "index after reset", 64'(round_idx_o), 64'd0);
        check("R1", "block after reset", block_o, 64'd0);

        // R2 R3 R4 R5 R6: vector table in both modes.
        for (int v = 0; v < 3; v++) begin
            make_subkeys(VEC[v][191:128]);
            run_op(1'b0, VEC[v][127:64], 1'b0, res, lat, idx_ok, pulse_ok);
            check("R3", "encrypt result", res, VEC[v][63:0]);
            check("R6", "encrypt latency", 64'(lat), 64'd16);
            check("R5", "encrypt index order", 64'(idx_ok), 64'd1);
            check("R6", "encrypt done width", 64'(pulse_ok), 64'd1);
            run_op(1'b1, VEC[v][63:0], 1'b0, res, lat, idx_ok, pulse_ok);
            check("R4", "decrypt result", res, VEC[v][127:64]);
            check("R5", "decrypt index order", 64'(idx_ok), 64'd1);
            check("R2", "decrypt latency", 64'(lat), 64'd16);
        end

        // R7 R9: start, mode and block changed mid-run are ignored.
        make_subkeys(VEC[0][191:128]);
        run_op(1'b0, VEC[0][127:64], 1'b1, res, lat, idx_ok, pulse_ok);
        check("R7", "disturbed encrypt result", res, VEC[0][63:0]);
        check("R7", "disturbed latency", 64'(lat), 64'd16);
        check("R9", "disturbed index order", 64'(idx_ok), 64'd1);
        run_op(1'b1, VEC[0][63:0], 1'b1, res, lat, idx_ok, pulse_ok);
        check("R9", "disturbed decrypt result", res, VEC[0][127:64]);

        // R8: result held while idle and after a start is released.
        held = block_o;
        start_i = 1'b0;
        block_i = 64'hDEADBEEFCAFEF00D;
        repeat (6) @(negedge clk);
        check("R8", "result held idle", block_o, held);
        check("R8", "idle busy", 64'(busy_o), 64'd0);

        // R1: reset mid-operation returns to idle with cleared outputs.
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0; block_i = VEC[1][127:64];
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "busy after mid-run reset", 64'(busy_o), 64'd0);
        check("R1", "block after mid-run reset", block_o, 64'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule